// File: doc/BRIEF.md
# Camera Sample Packer

This block sits between a camera receiver and a 32-bit capture FIFO. Each clock in which the receiver marks its 16-bit bus valid, the block takes one sample and places it in the next lane of a word it is building. When the word is full, the block presents it on the FIFO write port for exactly one clock.

A single mode bit selects how samples are packed. In narrow mode each sample is an 8-bit value taken from bits [9:2] of the bus, and four samples make a word. For 4:2:2 video this is half a pixel per clock. In wide mode each sample is the whole 16-bit bus, and two samples make a word, which is one pixel per clock. The mode is captured when a frame begins, so a change in the middle of a frame waits for the next frame.

A frame-start pulse throws away a partly built word and restarts at the lowest lane. If the FIFO is full when a word completes, that word is lost, a sticky overflow flag is raised, and packing goes on.

Top module: `cam_word_packer`

## Requirements
- R1: A synchronous active-high reset clears the write strobe, the overflow flag, the lane position and the partly built word. The first word after reset is therefore built only from samples given after reset.
- R2: In narrow mode (active mode 0) each accepted sample contributes in_data[9:2]. Four accepted samples form one word, with the first in wr_data[7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R3: In wide mode (active mode 1) each accepted sample contributes in_data[15:0]. Two accepted samples form one word, with the first in wr_data[15:0] and the second in [31:16].
- R4: wr_en is high for exactly one cycle, in the cycle after the clock edge that accepts the last sample of a group. wr_data holds the completed word in that cycle.
- R5: A cycle with in_valid low does not advance the lane position or change the partly built word. wr_en stays low in the cycle that follows it.
- R6: When frame_start is high, any partly built word is discarded. A sample accepted in that same cycle becomes lane 0 of a new word.
- R7: The active mode takes the value of wide_mode only in cycles where frame_start is high, and that value already applies to the sample in the same cycle. Changes of wide_mode at any other time have no effect.
- R8: If fifo_full is high in the cycle the last sample of a group is accepted, wr_en stays low for that word and overflow goes high. overflow stays high until reset, and packing continues with the next sample at lane 0.
- R9: After reset the active mode is narrow until the first frame_start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Start-of-frame pulse; captures the mode and restarts packing |
| wide_mode | input | 1 | 0 = four 8-bit samples per word, 1 = two 16-bit samples per word |
| in_valid | input | 1 | in_data carries a sample this cycle |
| in_data | input | 16 | Sample bus from the camera receiver |
| fifo_full | input | 1 | FIFO cannot take a word |
| wr_en | output | 1 | One-cycle FIFO write strobe |
| wr_data | output | 32 | Packed word for the FIFO |
| overflow | output | 1 | Sticky flag: a completed word was dropped |

## Verification
Two events can coincide in one cycle. A frame start can arrive together with a valid sample, so that a discard and a lane-0 write happen in the same cycle. A word can also complete while the FIFO reports full. The bench provokes the first by raising frame_start on a sample that falls midway through a word, sometimes with the mode changed in the same cycle. It judges the result from the next word written, which must hold only the new frame's samples, packed in the new mode. It provokes the second by holding fifo_full on a group's last sample. It then checks that no strobe follows, that overflow rises and stays high, and that the following group is written normally.

// File: rtl/cam_word_packer.sv
module cam_word_packer #(
  parameter int IN_W       = 16,
  parameter int OUT_W      = 32,
  parameter int NARROW_W   = 8,
  parameter int NARROW_LSB = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             wide_mode,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic             fifo_full,
  output logic             wr_en,
  output logic [OUT_W-1:0] wr_data,
  output logic             overflow
);
  localparam int NARROW_LANES = OUT_W / NARROW_W;
  localparam int WIDE_LANES   = OUT_W / IN_W;
  localparam int LANE_W       = $clog2(NARROW_LANES);

  logic              wide_q;
  logic [LANE_W-1:0] lane_q;
  logic [OUT_W-1:0]  acc_q;

  logic              eff_wide;
  logic [LANE_W-1:0] base_lane;
  logic [OUT_W-1:0]  base_acc;
  logic [OUT_W-1:0]  merged;
  logic              last;

  assign eff_wide  = frame_start ? wide_mode : wide_q;
  assign base_lane = frame_start ? '0 : lane_q;
  assign base_acc  = frame_start ? '0 : acc_q;
  assign last      = eff_wide ? (int'(base_lane) == WIDE_LANES - 1)
                              : (int'(base_lane) == NARROW_LANES - 1);

  always_comb begin
    merged = base_acc;
    if (eff_wide)
      merged[int'(base_lane)*IN_W +: IN_W] = in_data;
    else
      merged[int'(base_lane)*NARROW_W +: NARROW_W] = in_data[NARROW_LSB +: NARROW_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q   <= 1'b0;
      lane_q   <= '0;
      acc_q    <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      overflow <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (frame_start) begin
        wide_q <= wide_mode;
        lane_q <= '0;
        acc_q  <= '0;
      end
      if (in_valid) begin
        if (last) begin
          lane_q  <= '0;
          acc_q   <= '0;
          wr_en   <= !fifo_full;
          wr_data <= merged;
          if (fifo_full) overflow <= 1'b1;
        end else begin
          lane_q <= base_lane + LANE_W'(1);
          acc_q  <= merged;
        end
      end
    end
  end
endmodule

module cam_word_packer_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic fifo_full,
  input logic wr_en,
  input logic overflow
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!wr_en && !overflow));
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  a_r4_strobe_after_sample: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(in_valid));
  a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(fifo_full));
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(in_valid && fifo_full));
endmodule

bind cam_word_packer cam_word_packer_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .fifo_full(fifo_full),
  .wr_en(wr_en), .overflow(overflow)
);

// File: tb/tb_cam_word_packer.sv
`timescale 1ns/1ps
module tb_cam_word_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        wide_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        fifo_full = 1'b0;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        overflow;

  int tests = 0;
  int fails = 0;

  // reference state, derived from the requirements
  bit        m_wide = 0;
  int        m_lane = 0;
  bit [31:0] m_acc  = '0;
  bit        m_ovf  = 0;

  always #4 clk = ~clk;

  cam_word_packer dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wide_mode(wide_mode),
    .in_valid(in_valid), .in_data(in_data), .fifo_full(fifo_full),
    .wr_en(wr_en), .wr_data(wr_data), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 0; frame_start = 0; fifo_full = 0;
    @(negedge clk);
    @(negedge clk);
    chk(wr_en === 1'b0, "R1 wr_en in reset", {31'd0, wr_en}, 0);
    chk(overflow === 1'b0, "R1 overflow in reset", {31'd0, overflow}, 0);
    m_wide = 0; m_lane = 0; m_acc = '0; m_ovf = 0;
    rst = 1'b0;
  endtask

  task automatic send(input logic [15:0] d, input bit fs, input bit wm, input bit full, input string tag);
    bit last;
    bit [31:0] word;
    bit exp_wr;
    in_valid = 1; in_data = d; frame_start = fs; wide_mode = wm; fifo_full = full;
    if (fs) begin m_wide = wm; m_lane = 0; m_acc = '0; end
    if (m_wide) m_acc[m_lane*16 +: 16] = d;
    else        m_acc[m_lane*8 +: 8]   = d[9:2];
    last   = m_wide ? (m_lane == 1) : (m_lane == 3);
    exp_wr = last && !full;
    if (last && full) m_ovf = 1;
    word = m_acc;
    if (last) begin m_lane = 0; m_acc = '0; end
    else m_lane++;
    @(negedge clk);
    in_valid = 0; frame_start = 0; fifo_full = 0;
    chk(wr_en === exp_wr, {"R4 strobe ", tag}, {31'd0, wr_en}, {31'd0, exp_wr});
    if (exp_wr)
      chk(wr_data === word, {m_wide ? "R3 " : "R2 ", tag}, wr_data, word);
    chk(overflow === m_ovf, {"R8 overflow ", tag}, {31'd0, overflow}, {31'd0, m_ovf});
  endtask

  task automatic idle(input bit full);
    in_valid = 0; fifo_full = full; frame_start = 0;
    @(negedge clk);
    fifo_full = 0;
    chk(wr_en === 1'b0, "R5 no strobe after idle", {31'd0, wr_en}, 0);
  endtask

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();

    // R9: wide_mode high but no frame start yet -> narrow packing
    for (int i = 0; i < 4; i++) send(16'h0004 * (i + 1), 0, 1, 0, "R9 narrow after reset");

    // R2 explicit: bytes from [9:2]
    send(16'hFC07, 1, 0, 0, "R2 a");
    send(16'h0003, 0, 0, 0, "R2 b");
    send(16'h03FC, 0, 0, 0, "R2 c");
    send(16'h0155, 0, 0, 0, "R2 d");
    // expected {0x55,0xFF,0x00,0x01}
    chk(wr_data === 32'h55FF0001, "R2 explicit word", wr_data, 32'h55FF0001);

    // R3 explicit
    send(16'hA1B2, 1, 1, 0, "R3 a");
    send(16'hC3D4, 0, 1, 0, "R3 b");
    chk(wr_data === 32'hC3D4A1B2, "R3 explicit word", wr_data, 32'hC3D4A1B2);

    // sweeps over both modes with idle gaps (R5)
    for (int m = 0; m < 2; m++) begin
      send(16'h1234, 1, bit'(m), 0, "sweep start");
      for (int i = 0; i < 200; i++) begin
        send(16'(i * 40503 + 7919), 0, bit'(m), 0, "sweep");
        if (i % 5 == 3) idle(0);
        if (i % 7 == 2) idle(1);
      end
    end

    // R6: frame start midway through a word, same-cycle sample at lane 0
    send(16'h1111, 1, 0, 0, "R6 pre");
    send(16'h2222, 0, 0, 0, "R6 pre");
    send(16'h0AAA, 1, 0, 0, "R6 restart");
    for (int i = 0; i < 3; i++) send(16'(16'h0100 + i * 16'h0044), 0, 0, 0, "R6 after");
    // mode switch together with discard
    send(16'h3333, 0, 0, 0, "R6 pre2");
    send(16'hBEEF, 1, 1, 0, "R6 R7 switch");
    send(16'hCAFE, 0, 1, 0, "R6 R7 switch");

    // R7: mid-frame changes of wide_mode are ignored
    send(16'h5555, 1, 0, 0, "R7 narrow frame");
    for (int i = 0; i < 7; i++) send(16'(i * 16'h0123), 0, 1, 0, "R7 ignored flip");
    send(16'h6666, 1, 1, 0, "R7 wide frame");
    for (int i = 0; i < 5; i++) send(16'(i * 16'h0F0F), 0, 0, 0, "R7 ignored flip");

    // R8: full on completing sample, then normal words
    send(16'h0010, 1, 0, 0, "R8 g1");
    send(16'h0020, 0, 0, 0, "R8 g1");
    send(16'h0030, 0, 0, 1, "R8 full mid");
    send(16'h0040, 0, 0, 1, "R8 dropped");
    for (int i = 0; i < 8; i++) send(16'(i * 16'h0104), 0, 0, 0, "R8 continue");
    send(16'h7777, 1, 1, 0, "R8 wide");
    send(16'h8888, 0, 1, 1, "R8 wide dropped");
    send(16'h9999, 0, 1, 0, "R8 wide next");
    send(16'hAAAA, 0, 1, 0, "R8 wide next");

    // R1: reset clears overflow and partial word
    send(16'h0400, 1, 0, 0, "R1 partial");
    send(16'h0800, 0, 0, 0, "R1 partial");
    do_reset();
    chk(overflow === 1'b0, "R1 overflow cleared", {31'd0, overflow}, 0);
    for (int i = 0; i < 4; i++) send(16'(16'h0004 << i), 0, 0, 0, "R1 fresh word");

    finish_run();
  end
endmodule